// File: doc/BRIEF.md
# Floating-point exception status register

This block keeps the exception state that a floating-point unit reports. It handles five exception kinds: invalid operation, overflow, divide-by-zero, underflow and inexact. For each kind it holds three bits. The enable bit decides whether the kind raises a trap. The cause bit shows what the most recent operation reported. The sticky flag records masked occurrences until software clears it.

The arithmetic unit reports each finished operation by pulsing `op_done` with its five-bit cause vector. Software sets the enables, flags and causes through a single write strobe and reads them back on three read buses. When a reported kind is enabled, the block raises `exc_req` for one cycle toward the processor's trap logic. In that case the handler learns which kind occurred by reading the cause bits. When the kind is masked, the flag simply accumulates, and software can inspect it after a series of operations.

Top module: `fp_exc_status`

## Requirements
- R1: After reset, `rd_enable`, `rd_cause` and `rd_flag` are all zero and `exc_req` is 0.
- R2: Every five-bit vector uses the same bit order: bit 0 invalid operation, bit 1 overflow, bit 2 divide-by-zero, bit 3 underflow, bit 4 inexact. On a cycle with `op_done` high, `rd_cause` takes the full value of `op_cause` at the next clock edge, and kinds that did not occur read 0.
- R3: On a strobe, a flag bit is set when its cause bit is 1 and its enable bit is 0.
- R4: On a strobe, an exception whose enable bit is 1 sets only its cause bit and leaves its flag bit unchanged.
- R5: A flag bit that is 1 stays 1 through later strobes, including strobes with a zero cause vector. Only a software write can clear it.
- R6: `exc_req` is 1 in the single cycle after a strobe in which at least one `op_cause` bit is 1 while its enable bit is 1.
- R7: `exc_req` is 0 in the cycle after a strobe whose occurring causes are all masked, and in the cycle after any cycle without a strobe.
- R8: When `sw_we` and `op_done` are high in the same cycle, the new flags are `sw_flag` OR the hardware-set bits, and the new enables are `sw_enable`. Both the hardware-set bits and the request use the enables as they were before the write.
- R9: A write with `sw_we` loads `sw_enable` into the enables and `sw_flag` into the flags. It loads `sw_cause` into the causes only when no strobe occurs in that cycle; a strobe in the same cycle wins for the causes.
- R10: With neither `op_done` nor `sw_we` high, the enables, causes and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_done | input | 1 | Operation completion strobe |
| op_cause | input | 5 | Exception causes reported by the finished operation |
| sw_we | input | 1 | Software write strobe |
| sw_enable | input | 5 | Enable bits to write |
| sw_cause | input | 5 | Cause bits to write |
| sw_flag | input | 5 | Flag bits to write |
| rd_enable | output | 5 | Current enable bits |
| rd_cause | output | 5 | Current cause bits |
| rd_flag | output | 5 | Current sticky flag bits |
| exc_req | output | 1 | Exception request to the trap logic, a one-cycle pulse |

## Verification
Every result is registered, so all three read buses and `exc_req` show the effect of a strobe or a write exactly one clock edge after that cycle, and `exc_req` falls again one edge later. The bench applies each table row at a falling edge and samples the outputs at the next falling edge, so every check looks at the state one rising edge after its stimulus. Concurrent write and strobe rows check that the request and the hardware-set flags follow the enables as they were before the write. The idle rows that follow confirm that the request has dropped back to 0.

// File: rtl/fp_exc_status.sv
module fp_exc_status #(
  parameter int unsigned KINDS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_done,
  input  logic [KINDS-1:0] op_cause,
  input  logic             sw_we,
  input  logic [KINDS-1:0] sw_enable,
  input  logic [KINDS-1:0] sw_cause,
  input  logic [KINDS-1:0] sw_flag,
  output logic [KINDS-1:0] rd_enable,
  output logic [KINDS-1:0] rd_cause,
  output logic [KINDS-1:0] rd_flag,
  output logic             exc_req
);

  logic [KINDS-1:0] en_q, cause_q, flag_q;
  logic [KINDS-1:0] hw_set, trap_hit;
  logic             req_q;

  assign hw_set   = op_done ? (op_cause & ~en_q) : '0;
  assign trap_hit = op_done ? (op_cause &  en_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      cause_q <= '0;
      flag_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      if (sw_we) en_q <= sw_enable;
      if (op_done)    cause_q <= op_cause;
      else if (sw_we) cause_q <= sw_cause;
      flag_q <= (sw_we ? sw_flag : flag_q) | hw_set;
      req_q  <= |trap_hit;
    end
  end

  assign rd_enable = en_q;
  assign rd_cause  = cause_q;
  assign rd_flag   = flag_q;
  assign exc_req   = req_q;

endmodule

module fp_exc_status_chk #(
  parameter int unsigned KINDS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_done,
  input logic [KINDS-1:0] op_cause,
  input logic             sw_we,
  input logic [KINDS-1:0] sw_enable,
  input logic [KINDS-1:0] sw_cause,
  input logic [KINDS-1:0] sw_flag,
  input logic [KINDS-1:0] rd_enable,
  input logic [KINDS-1:0] rd_cause,
  input logic [KINDS-1:0] rd_flag,
  input logic             exc_req
);

  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> rd_cause == $past(op_cause)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> (rd_flag & $past(rd_flag)) == $past(rd_flag)); // R5

  AST_MASKED_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (($past(op_cause) & ~$past(rd_enable)) & ~rd_flag) == '0); // R3

  AST_ENABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !sw_we) |=> ((rd_flag & ~$past(rd_flag)) & $past(rd_enable)) == '0); // R4

  AST_REQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && ((op_cause & rd_enable) != '0)) |=> exc_req); // R6

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> !exc_req); // R7

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> rd_enable == $past(sw_enable)); // R8

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> $stable(rd_enable)); // R10

  AST_CAUSE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !op_done) |=> rd_cause == $past(sw_cause)); // R9

endmodule

bind fp_exc_status fp_exc_status_chk #(.KINDS(KINDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_cause(op_cause),
  .sw_we(sw_we), .sw_enable(sw_enable), .sw_cause(sw_cause), .sw_flag(sw_flag),
  .rd_enable(rd_enable), .rd_cause(rd_cause), .rd_flag(rd_flag), .exc_req(exc_req)
);

// File: tb/test_fp_exc_status.sv
module test_fp_exc_status;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_done = 1'b0;
  logic [4:0] op_cause = '0;
  logic       sw_we = 1'b0;
  logic [4:0] sw_enable = '0, sw_cause = '0, sw_flag = '0;
  logic [4:0] rd_enable, rd_cause, rd_flag;
  logic       exc_req;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  fp_exc_status i_fp_exc_status (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_cause(op_cause),
    .sw_we(sw_we), .sw_enable(sw_enable), .sw_cause(sw_cause), .sw_flag(sw_flag),
    .rd_enable(rd_enable), .rd_cause(rd_cause), .rd_flag(rd_flag), .exc_req(exc_req)
  );

  typedef struct packed {
    logic       we;
    logic [4:0] wen;
    logic [4:0] wflag;
    logic [4:0] wcause;
    logic       done;
    logic [4:0] opc;
    logic [4:0] x_en;
    logic [4:0] x_cause;
    logic [4:0] x_flag;
    logic       x_req;
  } row_t;

  localparam int ROWS = 12;
  localparam row_t TBL [ROWS] = '{
    // R3: masked invalid sets cause and flag
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b00001, 5'b00000, 5'b00001, 5'b00001, 1'b0},
    // R5: zero strobe clears cause, flag stays
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b00000, 5'b00000, 5'b00000, 5'b00001, 1'b0},
    // R9: write enables for overflow and divide-by-zero
    '{1'b1, 5'b00110, 5'b00001, 5'b00000, 1'b0, 5'b00000, 5'b00110, 5'b00000, 5'b00001, 1'b0},
    // R4 R6: enabled overflow raises request, no flag
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b00010, 5'b00110, 5'b00010, 5'b00001, 1'b1},
    // R10 R6: idle holds state, request drops
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b0, 5'b00000, 5'b00110, 5'b00010, 5'b00001, 1'b0},
    // R7: masked inexact and underflow, no request
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b11000, 5'b00110, 5'b11000, 5'b11001, 1'b0},
    // R6 R3: mixed enabled divide-by-zero and masked inexact
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b10100, 5'b00110, 5'b10100, 5'b11001, 1'b1},
    // R8: clearing write with strobe, old enables mask the strobe
    '{1'b1, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b01001, 5'b00000, 5'b01001, 5'b01001, 1'b0},
    // R8: enable-all write with strobe, request follows old enables
    '{1'b1, 5'b11111, 5'b00000, 5'b00000, 1'b1, 5'b00100, 5'b11111, 5'b00100, 5'b00100, 1'b0},
    // R4 R6: now enabled, flag unchanged
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b1, 5'b00100, 5'b11111, 5'b00100, 5'b00100, 1'b1},
    // R9: software clear of flags, cause written
    '{1'b1, 5'b00000, 5'b00000, 5'b10101, 1'b0, 5'b00000, 5'b00000, 5'b10101, 5'b00000, 1'b0},
    // R10: idle
    '{1'b0, 5'b00000, 5'b00000, 5'b00000, 1'b0, 5'b00000, 5'b00000, 5'b10101, 5'b00000, 1'b0}
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    sw_we = r.we; sw_enable = r.wen; sw_flag = r.wflag; sw_cause = r.wcause;
    op_done = r.done; op_cause = r.opc;
  endtask

  task automatic idle();
    sw_we = 1'b0; op_done = 1'b0; op_cause = '0;
    sw_enable = '0; sw_flag = '0; sw_cause = '0;
  endtask

  initial begin
    #(5 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 enable", rd_enable, 5'b0);
    chk("R1 cause", rd_cause, 5'b0);
    chk("R1 flag", rd_flag, 5'b0);
    chk("R1 req", {4'b0, exc_req}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < ROWS; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk("R9 enable", rd_enable, TBL[i].x_en);
      chk("R2 cause", rd_cause, TBL[i].x_cause);
      chk("R5 flag", rd_flag, TBL[i].x_flag);
      chk("R6 req", {4'b0, exc_req}, {4'b0, TBL[i].x_req});
    end
    idle();

    // R2: every cause bit loads individually, masked so R3 flags accumulate
    for (int b = 0; b < 5; b++) begin
      op_done = 1'b1; op_cause = 5'(1 << b);
      @(negedge clk);
      chk("R2 single cause", rd_cause, 5'(1 << b));
      chk("R3 flag accumulate", rd_flag, 5'((2 << b) - 1));
      chk("R7 masked no req", {4'b0, exc_req}, 5'b0);
    end
    idle();
    @(negedge clk);

    // R7: enabled pending cause, but no strobe means no request
    sw_we = 1'b1; sw_enable = 5'b11111; sw_cause = 5'b11111; sw_flag = 5'b00000;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R7 no strobe no req", {4'b0, exc_req}, 5'b0);
    chk("R10 cause held", rd_cause, 5'b11111);

    // R1: reset in mid-run clears everything
    op_done = 1'b1; op_cause = 5'b00011;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    chk("R1 reset enable", rd_enable, 5'b0);
    chk("R1 reset cause", rd_cause, 5'b0);
    chk("R1 reset flag", rd_flag, 5'b0);
    chk("R1 reset req", {4'b0, exc_req}, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule